// File: doc/BRIEF.md
# Sequential Shift-Subtract Divider

This block divides one unsigned integer by another, one quotient bit per clock cycle. A one-cycle `start` pulse captures the dividend and the divisor. The block then runs a restoring loop. On each step it shifts the partial remainder left by one place and brings in the next dividend bit from the top. It then trial-subtracts the divisor. A non-negative difference means the divisor fits: the quotient bit is 1 and the difference becomes the new remainder. A negative difference means the guess was wrong: the quotient bit is 0 and the shifted remainder is kept unchanged.

When the loop ends, the block pulses `done`. The quotient appears on `lo` and the remainder on `hi`, the usual pairing for a processor's multiply/divide result registers. A zero divisor skips the loop altogether. The block answers one cycle after `start`, raises a divide-by-zero flag, returns all-ones as the quotient and returns the dividend as the remainder. The results stay put until the next accepted `start`, so the consumer may read them at any time after `done`.

Top module: `seqDivider`

## Requirements
- R1: After reset, `busy`, `done` and `divZero` are 0, and `hi` and `lo` are 0.
- R2: When `start` is sampled high while idle and `divisor` is nonzero, `busy` is high from the next cycle for exactly W cycles. `done` is high for one cycle in the cycle where `busy` first reads low again.
- R3: On completion, `lo` equals floor(dividend / divisor) and `hi` equals dividend mod divisor, both read as unsigned W-bit numbers. For example, 38 / 5 gives `lo`=7 and `hi`=3.
- R4: Each step forms twice the remainder plus the next dividend bit. It subtracts the divisor only when the difference is non-negative, setting the quotient bit to 1, and otherwise sets the bit to 0. The partial remainder is therefore always below the divisor.
- R5: When `start` is sampled with `divisor` equal to 0, `busy` stays low and `done` is high in the next cycle. `divZero` reads 1, `lo` is all ones and `hi` equals the dividend.
- R6: An accepted `start` with a nonzero divisor clears `divZero` to 0.
- R7: From the `done` cycle until the next accepted `start`, `hi`, `lo` and `divZero` do not change, whatever the data inputs do.
- R8: A `start` pulse while `busy` is high is ignored: neither the result nor the completion cycle changes.
- R9: `dividend` and `divisor` are captured on the accepted `start`. Changing them afterwards has no effect on the running division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division; accepted only while idle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Division loop in progress |
| done | output | 1 | One-cycle completion pulse |
| divZero | output | 1 | Last accepted division had a zero divisor |
| hi | output | W | Remainder |
| lo | output | W | Quotient |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a running loop, together with data inputs that change under it. If either one leaked into the datapath, the only visible symptom would be a wrong result or a late `done` some cycles afterwards. The stimulus launches a division and then, partway through, pulses `start` again with different operands, including a zero divisor. It then checks that completion still comes exactly W cycles after the original `start` and that the result belongs to the original operands. A separate sequence moves from a zero-divisor result to a normal division, to show that the flag clears.

// File: rtl/divPkg.sv
package divPkg;
  typedef struct packed {
    logic load;      // capture operands, clear remainder
    logic loadZero;  // divide-by-zero shortcut result
    logic step;      // one shift / trial-subtract iteration
  } divStrobeT;
endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobeT    strobe,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         divisorZero,
  output logic [W-1:0] remOut,
  output logic [W-1:0] quoOut,
  output logic         zeroFlag
);
  localparam int SW = W + 1;   // shifted remainder width
  localparam int DW = W + 2;   // difference width incl. sign

  logic [W-1:0]  remReg;
  logic [W-1:0]  quoReg;
  logic [W-1:0]  divReg;
  logic          zeroReg;
  logic [SW-1:0] shifted;
  logic [DW-1:0] trialDiff;
  logic          fits;
  logic [W-1:0]  nextRem;
  logic [W-1:0]  nextQuo;

  assign divisorZero = (divisor == '0);

  always_comb begin
    shifted   = {remReg, quoReg[W-1]};
    trialDiff = {1'b0, shifted} - {2'b00, divReg};
    fits      = ~trialDiff[DW-1];
    nextRem   = fits ? trialDiff[W-1:0] : shifted[W-1:0];
    nextQuo   = {quoReg[W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      quoReg  <= '0;
      divReg  <= '0;
      zeroReg <= 1'b0;
    end else if (strobe.loadZero) begin
      remReg  <= dividend;
      quoReg  <= '1;
      divReg  <= '0;
      zeroReg <= 1'b1;
    end else if (strobe.load) begin
      remReg  <= '0;
      quoReg  <= dividend;
      divReg  <= divisor;
      zeroReg <= 1'b0;
    end else if (strobe.step) begin
      remReg  <= nextRem;
      quoReg  <= nextQuo;
    end
  end

  assign remOut   = remReg;
  assign quoOut   = quoReg;
  assign zeroFlag = zeroReg;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (remReg < divReg)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.step || strobe.load || strobe.loadZero) |=>
      ($stable(remReg) && $stable(quoReg) && $stable(zeroReg))); // R7
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadZero |=> (zeroReg && (quoReg == '1))); // R5
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !zeroReg); // R6
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      divisorZero,
  output divStrobeT strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic {IDLE, RUN} ctlStateT;

  ctlStateT      state;
  logic [CW-1:0] stepsLeft;
  logic          doneReg;

  always_comb begin
    strobe.load     = (state == IDLE) && start && !divisorZero;
    strobe.loadZero = (state == IDLE) && start && divisorZero;
    strobe.step     = (state == RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      stepsLeft <= '0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        IDLE: begin
          if (strobe.loadZero) begin
            doneReg <= 1'b1;
          end else if (strobe.load) begin
            state     <= RUN;
            stepsLeft <= CW'(W);
          end
        end
        RUN: begin
          stepsLeft <= stepsLeft - CW'(1);
          if (stepsLeft == CW'(1)) begin
            state   <= IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy = (state == RUN);
  assign done = doneReg;

  AST_RUN_HAS_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepsLeft != '0)); // R2
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.load || strobe.loadZero)); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) || $past(strobe.loadZero))); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)); // R2
endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         divZero,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  divStrobeT strobe;
  logic      divisorZero;

  divControl #(.W(W)) i_divControl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .divisorZero(divisorZero),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  divDatapath #(.W(W)) i_divDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dividend   (dividend),
    .divisor    (divisor),
    .divisorZero(divisorZero),
    .remOut     (hi),
    .quoOut     (lo),
    .zeroFlag   (divZero)
  );

  AST_ZERO_SKIPS_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisorZero) |=> (done && !busy)); // R5
endmodule

// File: tb/test_seqDivider.sv
module test_seqDivider;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, divZero;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  seqDivider #(.W(W)) i_seqDivider (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .divZero(divZero),
    .hi(hi), .lo(lo)
  );

  always #10 clk = ~clk;

  task automatic checkVal(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Pulse start at a negedge; returns sampled after the loading edge.
  task automatic pulseStart(input logic [W-1:0] a, input logic [W-1:0] b);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // Counts negedges until done, starting just after the loading edge.
  task automatic waitDone(output int cycles);
    cycles = 0;
    while (!done && cycles < 4 * W) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic runDiv(input logic [W-1:0] a, input logic [W-1:0] b);
    int cyc;
    pulseStart(a, b);
    checkVal("R2", "busy after start", busy, 1);
    waitDone(cyc);
    checkVal("R2", "cycles to done", cyc, W);
    checkVal("R2", "busy at done", busy, 0);
    checkVal("R3", "lo quotient", lo, a / b);
    checkVal("R3", "hi remainder", hi, a % b);
    checkVal("R6", "divZero clear", divZero, 0);
    @(negedge clk);
    checkVal("R2", "done one cycle", done, 0);
  endtask

  task automatic testReset();
    checkVal("R1", "busy", busy, 0);
    checkVal("R1", "done", done, 0);
    checkVal("R1", "divZero", divZero, 0);
    checkVal("R1", "hi", hi, 0);
    checkVal("R1", "lo", lo, 0);
  endtask

  task automatic testExample();
    runDiv(8'd38, 8'd5);  // R3 worked example: 7 remainder 3
    checkVal("R3", "example lo", lo, 7);
    checkVal("R3", "example hi", hi, 3);
  endtask

  task automatic testPatterns();
    runDiv(8'd255, 8'd1);   // R4 divisor fits every step
    runDiv(8'd0, 8'd7);     // R4 never fits
    runDiv(8'd5, 8'd255);   // R3 divisor larger than dividend
    runDiv(8'd255, 8'd255);
    runDiv(8'd200, 8'd13);
    runDiv(8'd128, 8'd2);
    runDiv(8'd254, 8'd128);
  endtask

  task automatic testZero();
    pulseStart(8'd77, 8'd0);
    checkVal("R5", "done next cycle", done, 1);
    checkVal("R5", "busy stays low", busy, 0);
    checkVal("R5", "divZero", divZero, 1);
    checkVal("R5", "lo all ones", lo, 255);
    checkVal("R5", "hi dividend", hi, 77);
    @(negedge clk);
    checkVal("R5", "done pulse ends", done, 0);
    checkVal("R7", "divZero held", divZero, 1);
    runDiv(8'd9, 8'd4);  // R6 flag clears on nonzero start
  endtask

  task automatic testHold();
    runDiv(8'd100, 8'd7);
    dividend = 8'd3;
    divisor  = 8'd0;
    repeat (5) @(negedge clk);
    checkVal("R7", "lo held", lo, 14);
    checkVal("R7", "hi held", hi, 2);
    checkVal("R7", "divZero held", divZero, 0);
    checkVal("R7", "done stays low", done, 0);
  endtask

  task automatic testBusyStart();
    int cyc;
    pulseStart(8'd250, 8'd9);
    repeat (3) @(negedge clk);
    dividend = 8'd1;   // R9 inputs change while running
    divisor  = 8'd0;
    start    = 1'b1;   // R8 start while busy
    @(negedge clk);
    divisor  = 8'd3;
    @(negedge clk);
    start    = 1'b0;
    waitDone(cyc);
    checkVal("R8", "cycles to done", cyc + 5, W);
    checkVal("R8", "lo unaffected", lo, 250 / 9);
    checkVal("R9", "hi unaffected", hi, 250 % 9);
    checkVal("R8", "no zero flag", divZero, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExample();
    testPatterns();
    testZero();
    testHold();
    testBusyStart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule